// File: doc/BRIEF.md
# Station-Address PROM Bus Decoder

This block terminates a host bus slave port in front of a network controller. It classifies each read or write by access window, offset and width. A legal access either reaches a 16-byte station-address store kept inside the block, or it is forwarded to the controller's register port. An access that matches no legal case is answered at once: a read returns all ones at the access width and a write is dropped.

There are two windows. In the I/O window, the low offsets map onto the address store. The legal widths and alignments there depend on a doubleword-I/O mode input. Higher offsets go to the register port for 16- and 32-bit accesses only. In the memory-mapped window, one address bit picks the store or the register port, and the bits below it give the offset. Store accesses there are legal at every width, whatever the mode. The master raises `busReq` and holds its fields until `busReady` pulses for one cycle, and drops the request in that cycle.

Top module: `prom_bus_decoder`

## Requirements
- R1: After reset, the address store holds the bytes of parameter `PROM_INIT`, byte j taken from bits [8j+7:8j].
- R2: Writes to the store take effect only while `cfgPromWe` is 1 at acceptance. Reads of the store are always allowed.
- R3: In the I/O window (`busWin`=0), offsets 0x00..0x0F address the store. Offsets 0x10 and up with `busSize` 1 (2 bytes) or 2 (4 bytes) are forwarded to the register port, carrying the unchanged offset, the size, the write flag and the write data. A byte access (`busSize` 0) at these offsets is not forwarded and reads all ones.
- R4: With `cfgDwordMode`=0, I/O-window store accesses are legal as bytes at any offset and as 2-byte accesses at even offsets. A 2-byte access at an odd offset and any 4-byte access are illegal.
- R5: With `cfgDwordMode`=1, the only legal I/O-window store access is a 4-byte access at an offset that is a multiple of 4.
- R6: An illegal read returns 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 0, 1 and 2, and 0xFFFFFFFF for the undefined size 3, with zero above the access width. An illegal write changes nothing.
- R7: Multi-byte store accesses are little-endian: the byte at the lowest offset sits in bits [7:0].
- R8: In the memory-mapped window (`busWin`=1), `busAddr[4]`=0 selects the store at offset `busAddr[3:0]`. Byte lanes wrap modulo 16. `busAddr[4]`=1 selects the register port at offset `busAddr[3:0]`, zero-extended.
- R9: In the memory-mapped window, a byte access with `busAddr[4]`=1 is not forwarded, and as a read it returns 0xFF.
- R10: In the memory-mapped window, store accesses of 1, 2 and 4 bytes are legal at any offset, whatever the value of `cfgDwordMode`.
- R11: A forwarded access holds `regReq` and its fields steady until `regReady` is 1. `busReady` pulses in the next cycle, and read data is masked to the access width.
- R12: Store accesses and rejected accesses raise `busReady` in the cycle after acceptance, for one cycle, with the read data already valid.
- R13: During reset and until the first request, `busReady` and `regReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWin | input | 1 | 0 = I/O window, 1 = memory-mapped window |
| busAddr | input | ADDR_W | Byte offset within the window |
| busSize | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = undefined |
| busWdata | input | 32 | Write data, lowest byte lane in [7:0] |
| busReady | output | 1 | One-cycle completion pulse |
| busRdata | output | 32 | Read data, valid while busReady |
| cfgDwordMode | input | 1 | Doubleword-I/O mode |
| cfgPromWe | input | 1 | Address store write enable |
| regReq | output | 1 | Register port request |
| regWrite | output | 1 | Register port write flag |
| regOffset | output | ADDR_W | Register port offset |
| regSize | output | 2 | Register port size, same encoding as busSize |
| regWdata | output | 32 | Register port write data |
| regReady | input | 1 | Register port completion |
| regRdata | input | 32 | Register port read data |

## Verification
The bench first reads every store byte in the I/O window, which checks the reset contents and the one-cycle latency. It then runs even and odd 2-byte accesses, 4-byte accesses and the undefined size with the mode bit clear, and repeats the pattern with it set. The two passes separate the mode-dependent rules from the width masking of all-ones reads. Writes are issued with the enable off, at illegal alignments and in the wrong mode. Each one is followed by a read-back, which shows whether a dropped write left the store untouched. Memory-mapped accesses at odd offsets and across the wrap point, byte accesses aimed at the register half, and forwarded accesses whose offset, size and data are compared at the register port separate the two window decoders.

// File: rtl/prom_dec_pkg.sv
package prom_dec_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REG  = 2'd1,
    ST_DONE = 2'd2
  } decState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // request taken this cycle
    logic promWr;    // commit byte lanes to the store
    logic loadProm;  // capture assembled store word
    logic loadOnes;  // capture all-ones at access width
    logic loadReg;   // capture register port read data
  } ctrlStrobe_t;

  function automatic logic [DATA_W-1:0] widthMask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: widthMask = 32'h0000_00FF;
      SZ_HALF: widthMask = 32'h0000_FFFF;
      default: widthMask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int unsigned laneCount(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: laneCount = 1;
      SZ_HALF: laneCount = 2;
      default: laneCount = 4;
    endcase
  endfunction

endpackage

// File: rtl/prom_dec_ctrl.sv
module prom_dec_ctrl
  import prom_dec_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PROM_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic              busWin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              cfgDwordMode,
  input  logic              cfgPromWe,
  input  logic              regReady,
  output ctrlStrobe_t       strobe,
  output logic              busReady,
  output logic              regReq
);

  localparam int IDX_W = $clog2(PROM_BYTES);
  localparam logic [ADDR_W-1:0] PROM_LIMIT = ADDR_W'(PROM_BYTES);

  decState_t stateQ;
  logic      promHit;
  logic      regHit;
  logic      wideAcc;

  assign wideAcc = (busSize == SZ_HALF) || (busSize == SZ_WORD);

  // window decode
  always_comb begin
    promHit = 1'b0;
    regHit  = 1'b0;
    if (!busWin) begin
      if (busAddr < PROM_LIMIT) begin
        if (!cfgDwordMode)
          promHit = (busSize == SZ_BYTE) || ((busSize == SZ_HALF) && !busAddr[0]);
        else
          promHit = (busSize == SZ_WORD) && (busAddr[1:0] == 2'b00);
      end else begin
        regHit = wideAcc;
      end
    end else begin
      if (!busAddr[IDX_W])
        promHit = (busSize != SZ_BAD);
      else
        regHit = wideAcc;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.accept   = (stateQ == ST_IDLE) && busReq;
    strobe.promWr   = strobe.accept && promHit && busWrite && cfgPromWe;
    strobe.loadProm = strobe.accept && promHit && !busWrite;
    strobe.loadOnes = strobe.accept && !promHit && !regHit && !busWrite;
    strobe.loadReg  = (stateQ == ST_REG) && regReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: if (busReq) stateQ <= regHit ? ST_REG : ST_DONE;
        ST_REG:  if (regReady) stateQ <= ST_DONE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busReady = (stateQ == ST_DONE);
  assign regReq   = (stateQ == ST_REG);

endmodule

// File: rtl/prom_dec_datapath.sv
module prom_dec_datapath
  import prom_dec_pkg::*;
#(
  parameter int                    ADDR_W     = 5,
  parameter int                    PROM_BYTES = 16,
  parameter logic [8*PROM_BYTES-1:0] PROM_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              busWrite,
  input  logic              busWin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       regRdata,
  output logic [31:0]       busRdata,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regOffset,
  output logic [1:0]        regSize,
  output logic [31:0]       regWdata
);

  localparam int IDX_W = $clog2(PROM_BYTES);
  localparam int LANES = DATA_W / 8;

  logic [7:0]        promQ [PROM_BYTES];
  logic [7:0]        byteWd [PROM_BYTES];
  logic              byteWe [PROM_BYTES];
  logic [IDX_W-1:0]  laneIdx [LANES];
  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] rdataQ;
  logic [DATA_W-1:0] accMask;

  assign accMask = widthMask(busSize);

  // per-lane store index, wraps at the store size
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneIdx[i] = busAddr[IDX_W-1:0] + IDX_W'(i);
    assign readWord[8*i +: 8] = promQ[laneIdx[i]];
  end

  always_comb begin
    for (int j = 0; j < PROM_BYTES; j++) begin
      byteWe[j] = 1'b0;
      byteWd[j] = 8'h00;
      for (int i = 0; i < LANES; i++) begin
        if ((i < int'(laneCount(busSize))) && (int'(laneIdx[i]) == j)) begin
          byteWe[j] = strobe.promWr;
          byteWd[j] = busWdata[8*i +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < PROM_BYTES; j++) promQ[j] <= PROM_INIT[8*j +: 8];
    end else begin
      for (int j = 0; j < PROM_BYTES; j++)
        if (byteWe[j]) promQ[j] <= byteWd[j];
    end
  end

  // register port fields latched at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrite  <= 1'b0;
      regOffset <= '0;
      regSize   <= SZ_BYTE;
      regWdata  <= '0;
    end else if (strobe.accept) begin
      regWrite  <= busWrite;
      regOffset <= busWin ? ADDR_W'(busAddr[IDX_W-1:0]) : busAddr;
      regSize   <= busSize;
      regWdata  <= busWdata & accMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobe.loadProm) begin
      rdataQ <= readWord & accMask;
    end else if (strobe.loadOnes) begin
      rdataQ <= accMask;
    end else if (strobe.loadReg && !regWrite) begin
      rdataQ <= regRdata & widthMask(regSize);
    end
  end

  assign busRdata = rdataQ;

endmodule

// File: rtl/prom_bus_decoder.sv
module prom_bus_decoder
  import prom_dec_pkg::*;
#(
  parameter int                      ADDR_W     = 5,
  parameter int                      PROM_BYTES = 16,
  parameter logic [8*PROM_BYTES-1:0] PROM_INIT  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic              busWin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  input  logic              cfgDwordMode,
  input  logic              cfgPromWe,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regOffset,
  output logic [1:0]        regSize,
  output logic [31:0]       regWdata,
  input  logic              regReady,
  input  logic [31:0]       regRdata
);

  ctrlStrobe_t strobe;

  prom_dec_ctrl #(
    .ADDR_W    (ADDR_W),
    .PROM_BYTES(PROM_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busReq      (busReq),
    .busWrite    (busWrite),
    .busWin      (busWin),
    .busAddr     (busAddr),
    .busSize     (busSize),
    .cfgDwordMode(cfgDwordMode),
    .cfgPromWe   (cfgPromWe),
    .regReady    (regReady),
    .strobe      (strobe),
    .busReady    (busReady),
    .regReq      (regReq)
  );

  prom_dec_datapath #(
    .ADDR_W    (ADDR_W),
    .PROM_BYTES(PROM_BYTES),
    .PROM_INIT (PROM_INIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWrite (busWrite),
    .busWin   (busWin),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWdata (busWdata),
    .regRdata (regRdata),
    .busRdata (busRdata),
    .regWrite (regWrite),
    .regOffset(regOffset),
    .regSize  (regSize),
    .regWdata (regWdata)
  );

endmodule

// File: rtl/prom_dec_checker.sv
module prom_dec_checker #(
  parameter int ADDR_W     = 5,
  parameter int PROM_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic              busWin,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busReady,
  input logic [31:0]       busRdata,
  input logic              cfgDwordMode,
  input logic              regReq,
  input logic [ADDR_W-1:0] regOffset,
  input logic [1:0]        regSize,
  input logic              regReady
);

  localparam int IDX_W = $clog2(PROM_BYTES);

  logic acceptNow;
  assign acceptNow = busReq && !busReady && !regReq;

  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  p_reg_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regReady) |=> (regReq && $stable(regOffset) && $stable(regSize)));

  p_reg_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regReady) |=> (busReady && !regReq));

  p_reg_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> !busReady);

  p_reg_no_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> (regSize != 2'd0));

  p_dword_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    (acceptNow && !busWin && cfgDwordMode && (busSize == 2'd0) && !busWrite)
      |=> (busReady && (busRdata == 32'h0000_00FF)));

  p_mmio_reg_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    (acceptNow && busWin && busAddr[IDX_W] && (busSize == 2'd0))
      |=> (busReady && !regReq));

endmodule

bind prom_bus_decoder prom_dec_checker #(
  .ADDR_W    (ADDR_W),
  .PROM_BYTES(PROM_BYTES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busReq      (busReq),
  .busWrite    (busWrite),
  .busWin      (busWin),
  .busAddr     (busAddr),
  .busSize     (busSize),
  .busReady    (busReady),
  .busRdata    (busRdata),
  .cfgDwordMode(cfgDwordMode),
  .regReq      (regReq),
  .regOffset   (regOffset),
  .regSize     (regSize),
  .regReady    (regReady)
);

// File: tb/sim_prom_bus_decoder.sv
`timescale 1ns/1ps
module sim_prom_bus_decoder;

  localparam logic [127:0] INIT = 128'hEFCD_AB89_6745_2301_F0E1_D2C3_B4A5_9687;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWrite = 1'b0, busWin = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdata;
  logic        cfgDwordMode = 1'b0, cfgPromWe = 1'b0;
  logic        regReq, regWrite;
  logic [4:0]  regOffset;
  logic [1:0]  regSize;
  logic [31:0] regWdata;
  logic        regReady = 1'b0;
  logic [31:0] regRdata = '0;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  prom_bus_decoder #(.ADDR_W(5), .PROM_BYTES(16), .PROM_INIT(INIT)) u0 (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busWin(busWin),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .cfgDwordMode(cfgDwordMode), .cfgPromWe(cfgPromWe),
    .regReq(regReq), .regWrite(regWrite), .regOffset(regOffset), .regSize(regSize),
    .regWdata(regWdata), .regReady(regReady), .regRdata(regRdata));

  typedef struct {
    logic [31:0] val;
    bit          chk;
    string       tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] model [16];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // register port responder
  int          regOps = 0;
  int          waitCnt = 0;
  logic [4:0]  lastOff;
  logic [1:0]  lastSize;
  logic        lastWr;
  logic [31:0] lastWd;

  function automatic logic [31:0] regResp(input logic [4:0] off);
    return 32'hC35A_9600 | 32'(off);
  endfunction

  always @(negedge clk) begin
    regReady <= 1'b0;
    if (rstN && regReq) begin
      if (waitCnt == 2) begin
        regReady <= 1'b1;
        regRdata <= regResp(regOffset);
        lastOff  <= regOffset;
        lastSize <= regSize;
        lastWr   <= regWrite;
        lastWd   <= regWdata;
        regOps++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && busReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "unexpected busReady", busRdata, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.chk) check(busRdata === it.val, it.tag, busRdata, it.val);
      end
    end
  end

  function automatic logic [31:0] promLE(input int base, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) w[8*i +: 8] = model[(base + i) % 16];
    return w;
  endfunction

  task automatic doAcc(input bit win, input logic [4:0] addr, input logic [1:0] sz,
                       input bit wr, input logic [31:0] wd, input logic [31:0] expv,
                       input string tag, input int expLat);
    expItem_t it;
    int lat = 0;
    it.val = expv;
    it.chk = !wr;
    it.tag = tag;
    expQ.push_back(it);
    busWin = win; busAddr = addr; busSize = sz; busWrite = wr; busWdata = wd;
    busReq = 1'b1;
    do begin
      @(negedge clk);
      lat++;
    end while (!busReady && lat < 50);
    busReq = 1'b0;
    if (expLat > 0) check(lat == expLat, {tag, " latency R12"}, 32'(lat), 32'(expLat));
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ops;
    for (int j = 0; j < 16; j++) model[j] = INIT[8*j +: 8];
    repeat (3) @(negedge clk);
    check(busReady == 1'b0, "R13 busReady in reset", 32'(busReady), 0);
    check(regReq == 1'b0, "R13 regReq in reset", 32'(regReq), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busReady == 1'b0 && regReq == 1'b0, "R13 idle after reset", 32'({busReady, regReq}), 0);

    // R1 contents, R12 latency
    for (int j = 0; j < 16; j++)
      doAcc(0, 5'(j), 2'd0, 0, 0, 32'(model[j]), "R1 byte read", 1);
    doAcc(0, 5'd2, 2'd1, 0, 0, promLE(2, 2), "R7 R4 half read even", 1);
    doAcc(0, 5'd3, 2'd1, 0, 0, 32'h0000_FFFF, "R4 R6 half read odd", 1);
    doAcc(0, 5'd0, 2'd2, 0, 0, 32'hFFFF_FFFF, "R4 word read mode0", 1);
    doAcc(0, 5'd0, 2'd3, 0, 0, 32'hFFFF_FFFF, "R6 undefined size", 1);

    // R2 write enable
    doAcc(0, 5'd5, 2'd0, 1, 32'h55, 0, "R2 write WE off", 1);
    doAcc(0, 5'd5, 2'd0, 0, 0, 32'(model[5]), "R2 readback WE off", 1);
    cfgPromWe = 1'b1;
    doAcc(0, 5'd4, 2'd1, 1, 32'h1234, 0, "R2 half write", 1);
    model[4] = 8'h34; model[5] = 8'h12;
    doAcc(0, 5'd4, 2'd1, 0, 0, 32'h0000_1234, "R2 R7 half readback", 1);
    doAcc(0, 5'd7, 2'd1, 1, 32'hBEEF, 0, "R6 odd half write", 1);
    doAcc(0, 5'd7, 2'd0, 0, 0, 32'(model[7]), "R6 odd write dropped lo", 1);
    doAcc(0, 5'd8, 2'd0, 0, 0, 32'(model[8]), "R6 odd write dropped hi", 1);

    // R5 doubleword mode
    cfgDwordMode = 1'b1;
    doAcc(0, 5'd4, 2'd2, 0, 0, promLE(4, 4), "R5 R7 word read", 1);
    doAcc(0, 5'd4, 2'd0, 0, 0, 32'h0000_00FF, "R5 byte rejected", 1);
    doAcc(0, 5'd0, 2'd1, 0, 0, 32'h0000_FFFF, "R5 half rejected", 1);
    doAcc(0, 5'd2, 2'd2, 0, 0, 32'hFFFF_FFFF, "R5 misaligned word", 1);
    doAcc(0, 5'd8, 2'd2, 1, 32'hDEAD_BEEF, 0, "R5 word write", 1);
    model[8] = 8'hEF; model[9] = 8'hBE; model[10] = 8'hAD; model[11] = 8'hDE;
    doAcc(0, 5'd8, 2'd2, 0, 0, 32'hDEAD_BEEF, "R5 word readback", 1);
    doAcc(0, 5'd12, 2'd0, 1, 32'h00, 0, "R6 byte write in mode1", 1);
    doAcc(0, 5'd12, 2'd2, 0, 0, promLE(12, 4), "R6 mode1 byte write dropped", 1);

    // R3 register forwarding in I/O window
    doAcc(0, 5'h12, 2'd1, 0, 0, regResp(5'h12) & 32'hFFFF, "R3 R11 reg half read", 0);
    check(lastOff == 5'h12 && lastSize == 2'd1 && lastWr == 1'b0, "R3 reg fields read",
          {lastWr, 25'(0), lastSize, lastOff}, {1'b0, 25'(0), 2'd1, 5'h12});
    doAcc(0, 5'h14, 2'd2, 1, 32'hCAFE_F00D, 0, "R3 reg word write", 0);
    check(lastOff == 5'h14 && lastWr == 1'b1 && lastSize == 2'd2, "R3 reg fields write",
          32'(lastOff), 32'h14);
    check(lastWd == 32'hCAFE_F00D, "R3 reg wdata", lastWd, 32'hCAFE_F00D);
    doAcc(0, 5'h1C, 2'd2, 0, 0, regResp(5'h1C), "R11 reg word read", 0);
    ops = regOps;
    doAcc(0, 5'h11, 2'd0, 0, 0, 32'h0000_00FF, "R3 byte in reg range", 1);
    check(regOps == ops, "R3 byte not forwarded", 32'(regOps), 32'(ops));

    // memory-mapped window, mode bit still set
    doAcc(1, 5'd3, 2'd0, 0, 0, 32'(model[3]), "R10 mmio byte", 1);
    doAcc(1, 5'd5, 2'd1, 0, 0, promLE(5, 2), "R10 mmio odd half", 1);
    doAcc(1, 5'd14, 2'd2, 0, 0, promLE(14, 4), "R8 mmio wrap word", 1);
    doAcc(1, 5'h13, 2'd1, 0, 0, regResp(5'h03) & 32'hFFFF, "R8 mmio reg half", 0);
    check(lastOff == 5'h03, "R8 mmio reg offset", 32'(lastOff), 32'h3);
    ops = regOps;
    doAcc(1, 5'h15, 2'd0, 0, 0, 32'h0000_00FF, "R9 mmio reg byte read", 1);
    doAcc(1, 5'h15, 2'd0, 1, 32'h44, 0, "R9 mmio reg byte write", 1);
    check(regOps == ops, "R9 byte not forwarded", 32'(regOps), 32'(ops));
    doAcc(1, 5'h1C, 2'd2, 1, 32'h0102_0304, 0, "R8 mmio reg write", 0);
    check(lastOff == 5'h0C && lastWd == 32'h0102_0304, "R8 mmio reg write fields",
          32'(lastOff), 32'h0C);
    doAcc(1, 5'd1, 2'd0, 1, 32'h77, 0, "R10 mmio byte write", 1);
    model[1] = 8'h77;
    cfgDwordMode = 1'b0;
    doAcc(0, 5'd1, 2'd0, 0, 0, 32'h77, "R10 R2 mmio write visible", 1);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained R12", 32'(expQ.size()), 0);
    doneFlag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule